// File: doc/BRIEF.md
# Serializer PHY Power Sequencer

This block is a hardware sequencer that powers a TMDS serializer PHY up and down through a plain register-write port. A one-cycle start pulse samples the pixel clock frequency, given as an integer number of Hz. The sequencer looks the frequency up in a band table to get the PLL input and output divider settings. It then writes the PLL configuration word and waits, for a bounded number of clock cycles, for the PLL lock input. Once lock is seen it writes the serializer configuration word, then the current-control word, then the calibration-code word.

A one-cycle stop pulse runs the shutdown order. The serializer is left with only its two detection functions on, the PLL word is cleared, and the sequencer waits the same bounded time for lock to fall. A busy flag covers each running sequence. Done and error flags report the result of the last accepted command and hold until the next one is accepted. The analog PHY and the PLL are outside the block; lock comes in as an input.

Top module: `serdes_phy_seq`

## Requirements
- R1: The input divider and output divider code come from five pixel-clock bands, each including its lower edge and excluding its upper edge: [0, 20 MHz) gives divider 1 and code 3; [20, 42.5 MHz) gives 2 and code 3; [42.5, 85 MHz) gives 4 and code 2; [85, 170 MHz) gives 8 and code 1; [170, 340 MHz) gives 16 and code 0. The codes 0, 1, 2 and 3 stand for output division by 1, 2, 4 and 8.
- R2: The first write of an accepted start goes to address 0x510. Its data has bit 0 (enable) set, 40 in bits 15:8, the input divider in bits 23:16, the output divider code in bits 25:24, and all other bits clear.
- R3: A start with a pixel clock of 340 MHz or more makes no write, keeps busy low, and sets done and error in the next cycle.
- R4: After the PLL write the sequencer waits for lock for at most TIMEOUT_CYC cycles. If lock stays low, busy stays high for exactly TIMEOUT_CYC cycles, the PLL word is the only write, and done and error are set.
- R5: Once lock is seen, the next write goes to address 0x504 with bits 0, 16, 18 and 19 set, and bit 24 set exactly when the pixel clock is above 165 MHz.
- R6: The serializer word also carries the value 0x1110 exactly when the pixel clock is above 250 MHz and at most 300 MHz; this value lies clear of bits 0, 1, 16, 17, 18, 19 and 24. At 250 MHz or below and above 300 MHz, nothing is added.
- R7: The serializer write is followed, on the next two cycles, by a write of 0 to address 0x518 and then a write of 0 to address 0x520. Done is then set with error clear.
- R8: An accepted stop writes 0x000C0000 to address 0x504, then 0 to address 0x510, then waits at most TIMEOUT_CYC cycles for lock to fall. Done is set, and error is set only if lock is still high when the wait ends.
- R9: Start and stop pulses that arrive while busy is high have no effect on the writes or the result of the running sequence.
- R10: Each write lasts one cycle with the strobe high. The strobe is high only while busy is high, only to the four addresses above, and done is set only while busy is low.
- R11: After reset the strobe, busy, done and error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle power-up request |
| stop_i | input | 1 | One-cycle power-down request |
| pix_hz_i | input | 32 | Pixel clock frequency in Hz, sampled with start |
| lock_i | input | 1 | PLL lock indication |
| wr_en_o | output | 1 | Register-write strobe |
| wr_addr_o | output | 12 | Register-write address |
| wr_data_o | output | 32 | Register-write data |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | Last accepted command has finished |
| err_o | output | 1 | Last accepted command failed |

## Verification
The assertions watch the write port on every cycle. They check that the strobe stays inside a busy sequence and uses only the four legal addresses. They check that a calibration write always directly follows a current-control write, that every enabling PLL word carries the fixed feedback divider, that the wait counter never passes its limit, and that done never overlaps busy. Only the directed scenarios can show the right divider and serializer bits at each band edge. The same holds for the exact length of a failed lock wait, the rejection of out-of-range clocks, the error rule of the shutdown wait, and that pulses arriving mid-sequence leave the writes unchanged.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FREQ_W = 32;
  localparam int unsigned N_BANDS = 5;
  localparam int unsigned DIV_W = 8;
  localparam int unsigned ODF_W = 2;

  localparam logic [ADDR_W-1:0] ADR_SERIAL = 12'h504;
  localparam logic [ADDR_W-1:0] ADR_PLL    = 12'h510;
  localparam logic [ADDR_W-1:0] ADR_CURR   = 12'h518;
  localparam logic [ADDR_W-1:0] ADR_CALIB  = 12'h520;

  localparam logic [DIV_W-1:0] FB_DIV = 8'd40;

  // serializer word fields
  localparam logic [DATA_W-1:0] SER_ON       = 32'h0000_0001;
  localparam logic [DATA_W-1:0] SER_EXT_DATA = 32'h0001_0000;
  localparam logic [DATA_W-1:0] SER_SINK_DET = 32'h0004_0000;
  localparam logic [DATA_W-1:0] SER_BIAS_DET = 32'h0008_0000;
  localparam logic [DATA_W-1:0] SER_SRC_TERM = 32'h0100_0000;
  localparam logic [DATA_W-1:0] SER_OWN_MASK = 32'h010F_0003;
  localparam logic [DATA_W-1:0] SER_HI_EXTRA = 32'h0000_1110;

  localparam logic [FREQ_W-1:0] TERM_ABOVE_HZ  = 32'd165_000_000;
  localparam logic [FREQ_W-1:0] EXTRA_ABOVE_HZ = 32'd250_000_000;
  localparam logic [FREQ_W-1:0] EXTRA_UPTO_HZ  = 32'd300_000_000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCK_WAIT, ST_CURR, ST_CALIB, ST_FINISH, ST_DN_PLL, ST_DN_WAIT
  } seq_state_e;

  typedef struct packed {
    logic              valid;
    logic [DIV_W-1:0]  in_div;
    logic [ODF_W-1:0]  out_code;
    logic              src_term;
    logic              hi_extra;
  } band_cfg_t;

  // lower edge of band i; edge N_BANDS is the upper limit
  function automatic logic [FREQ_W-1:0] band_edge(input int unsigned i);
    case (i)
      0:       band_edge = 32'd0;
      1:       band_edge = 32'd20_000_000;
      2:       band_edge = 32'd42_500_000;
      3:       band_edge = 32'd85_000_000;
      4:       band_edge = 32'd170_000_000;
      default: band_edge = 32'd340_000_000;
    endcase
  endfunction

  function automatic logic [ODF_W-1:0] band_odf(input int unsigned i);
    case (i)
      0, 1:    band_odf = 2'd3;
      2:       band_odf = 2'd2;
      3:       band_odf = 2'd1;
      default: band_odf = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/physeq_band_decode.sv
module physeq_band_decode
  import physeq_pkg::*;
(
  input  logic [FREQ_W-1:0] freq_i,
  output band_cfg_t         cfg_o
);

  always_comb begin
    cfg_o = '0;
    for (int unsigned i = 0; i < N_BANDS; i++) begin
      if (!cfg_o.valid && freq_i >= band_edge(i) && freq_i < band_edge(i + 1)) begin
        cfg_o.valid    = 1'b1;
        cfg_o.in_div   = DIV_W'(1) << i;
        cfg_o.out_code = band_odf(i);
      end
    end
    cfg_o.src_term = (freq_i > TERM_ABOVE_HZ);
    cfg_o.hi_extra = (freq_i > EXTRA_ABOVE_HZ) && (freq_i <= EXTRA_UPTO_HZ);
  end

endmodule

// File: rtl/physeq_wait_timer.sv
module physeq_wait_timer #(
  parameter int unsigned LIMIT = 6_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)            cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  // R4: the wait count never runs past its limit
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/serdes_phy_seq.sv
module serdes_phy_seq
  import physeq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 6_250_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [FREQ_W-1:0] pix_hz_i,
  input  logic              lock_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  seq_state_e        state_q, state_d;
  logic              wr_en_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [DATA_W-1:0] wr_data_d;
  logic              done_d, err_d;
  logic [DATA_W-1:0] ser_q, ser_d;
  logic              ser_en;
  band_cfg_t         cfg;
  logic              waiting, expired;
  logic [DATA_W-1:0] pll_word, ser_word;

  physeq_band_decode u_band (
    .freq_i (pix_hz_i),
    .cfg_o  (cfg)
  );

  assign waiting = (state_q == ST_LOCK_WAIT) || (state_q == ST_DN_WAIT);

  physeq_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (waiting),
    .expired_o (expired)
  );

  assign pll_word = {6'd0, cfg.out_code, cfg.in_div, FB_DIV, 8'h01};
  assign ser_word = SER_ON | SER_EXT_DATA | SER_SINK_DET | SER_BIAS_DET
                  | (cfg.src_term ? SER_SRC_TERM : '0)
                  | (cfg.hi_extra ? (SER_HI_EXTRA & ~SER_OWN_MASK) : '0);

  always_comb begin
    state_d   = state_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_o;
    wr_data_d = wr_data_o;
    done_d    = done_o;
    err_d     = err_o;
    ser_d     = ser_q;
    ser_en    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          done_d = 1'b0;
          err_d  = 1'b0;
          if (cfg.valid) begin
            wr_en_d   = 1'b1;
            wr_addr_d = ADR_PLL;
            wr_data_d = pll_word;
            ser_d     = ser_word;
            ser_en    = 1'b1;
            state_d   = ST_LOCK_WAIT;
          end else begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end
        end else if (stop_i) begin
          done_d    = 1'b0;
          err_d     = 1'b0;
          wr_en_d   = 1'b1;
          wr_addr_d = ADR_SERIAL;
          wr_data_d = SER_SINK_DET | SER_BIAS_DET;
          state_d   = ST_DN_PLL;
        end
      end
      ST_LOCK_WAIT: begin
        if (lock_i) begin
          wr_en_d   = 1'b1;
          wr_addr_d = ADR_SERIAL;
          wr_data_d = ser_q;
          state_d   = ST_CURR;
        end else if (expired) begin
          done_d  = 1'b1;
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_CURR: begin
        wr_en_d   = 1'b1;
        wr_addr_d = ADR_CURR;
        wr_data_d = '0;
        state_d   = ST_CALIB;
      end
      ST_CALIB: begin
        wr_en_d   = 1'b1;
        wr_addr_d = ADR_CALIB;
        wr_data_d = '0;
        state_d   = ST_FINISH;
      end
      ST_FINISH: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_DN_PLL: begin
        wr_en_d   = 1'b1;
        wr_addr_d = ADR_PLL;
        wr_data_d = '0;
        state_d   = ST_DN_WAIT;
      end
      ST_DN_WAIT: begin
        if (!lock_i) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (expired) begin
          done_d  = 1'b1;
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      ser_q     <= '0;
    end else begin
      state_q <= state_d;
      wr_en_o <= wr_en_d;
      done_o  <= done_d;
      err_o   <= err_d;
      if (wr_en_d) begin
        wr_addr_o <= wr_addr_d;
        wr_data_o <= wr_data_d;
      end
      if (ser_en) ser_q <= ser_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  // R10: strobe only inside a running sequence
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !wr_en_o);

  // R10: strobe only to the four legal offsets
  a_r10_legal_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_addr_o == ADR_SERIAL || wr_addr_o == ADR_PLL ||
                 wr_addr_o == ADR_CURR   || wr_addr_o == ADR_CALIB));

  // R10: result flags never overlap a running sequence
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7: calibration write comes right after the current-control write
  a_r7_calib_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o == ADR_CALIB) |->
      ($past(wr_en_o) && $past(wr_addr_o) == ADR_CURR));

  // R2: an enabling PLL word carries the fixed feedback divider
  a_r2_fb_div: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o == ADR_PLL && wr_data_o[0]) |->
      (wr_data_o[15:8] == FB_DIV));

endmodule

// File: tb/serdes_phy_seq_tb_top.sv
module serdes_phy_seq_tb_top;

  localparam int unsigned TMO = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [31:0] pix_hz_i = '0;
  logic        lock_i = 1'b0;
  logic        wr_en_o;
  logic [11:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic        busy_o, done_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [11:0] log_a [8];
  logic [31:0] log_d [8];
  int          log_n = 0;

  always #4 clk = ~clk;

  serdes_phy_seq #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .pix_hz_i(pix_hz_i), .lock_i(lock_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  always @(negedge clk) begin
    if (rst_n && wr_en_o) begin
      if (log_n < 8) begin
        log_a[log_n] = wr_addr_o;
        log_d[log_n] = wr_data_o;
      end
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pll(input logic [31:0] f);
    logic [7:0] idf;
    logic [1:0] odf;
    if (f < 32'd20_000_000)       begin idf = 8'd1;  odf = 2'd3; end
    else if (f < 32'd42_500_000)  begin idf = 8'd2;  odf = 2'd3; end
    else if (f < 32'd85_000_000)  begin idf = 8'd4;  odf = 2'd2; end
    else if (f < 32'd170_000_000) begin idf = 8'd8;  odf = 2'd1; end
    else                          begin idf = 8'd16; odf = 2'd0; end
    return {6'd0, odf, idf, 8'd40, 8'h01};
  endfunction

  function automatic logic [31:0] exp_ser(input logic [31:0] f);
    logic [31:0] w;
    w = 32'h000D_0001;
    if (f > 32'd165_000_000) w = w | 32'h0100_0000;
    if (f > 32'd250_000_000 && f <= 32'd300_000_000) w = w | 32'h0000_1110;
    return w;
  endfunction

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    #1;
  endtask

  // R1 R2 R5 R6 R7 R9: full bring-up with lock after `dly` cycles
  task automatic t_start_ok(input logic [31:0] f, input int dly, input bit poke);
    log_n = 0;
    @(negedge clk); start_i = 1'b1; pix_hz_i = f;
    @(negedge clk); start_i = 1'b0; pix_hz_i = 32'd5_000_000;
    for (int k = 0; k < dly; k++) begin
      if (poke && k == 0) begin start_i = 1'b1; stop_i = 1'b1; end
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
    end
    lock_i = 1'b1;
    wait_idle();
    check(log_n == 4, "R7 write count", log_n, 4);
    check(log_a[0] == 12'h510 && log_d[0] == exp_pll(f), "R1/R2 pll word",
          log_d[0], exp_pll(f));
    check(log_a[1] == 12'h504 && log_d[1] == exp_ser(f), "R5/R6 serializer word",
          log_d[1], exp_ser(f));
    check(log_a[2] == 12'h518 && log_d[2] == 0, "R7 current-control write",
          {20'd0, log_a[2]}, 32'h518);
    check(log_a[3] == 12'h520 && log_d[3] == 0, "R7 calibration write",
          {20'd0, log_a[3]}, 32'h520);
    check(done_o && !err_o, "R7 done without error", {done_o, err_o}, 2'b10);
    if (poke) check(log_d[0] == exp_pll(f), "R9 mid-sequence pulses ignored",
                    log_d[0], exp_pll(f));
  endtask

  // R3: out-of-range clock
  task automatic t_reject(input logic [31:0] f);
    int b = 0;
    log_n = 0;
    @(negedge clk); start_i = 1'b1; pix_hz_i = f;
    @(negedge clk); start_i = 1'b0;
    if (busy_o) b++;
    #1;
    check(done_o && err_o && b == 0, "R3 reject flags", {done_o, err_o, busy_o}, 3'b110);
    repeat (3) @(negedge clk);
    #1;
    check(log_n == 0, "R3 no write", log_n, 0);
  endtask

  // R4: lock never arrives
  task automatic t_timeout();
    int n = 0;
    lock_i = 1'b0;
    log_n = 0;
    @(negedge clk); start_i = 1'b1; pix_hz_i = 32'd100_000_000;
    @(negedge clk); start_i = 1'b0;
    while (busy_o) begin n++; @(negedge clk); end
    #1;
    check(n == TMO, "R4 wait length", n, TMO);
    check(log_n == 1 && log_a[0] == 12'h510, "R4 only pll write", log_n, 1);
    check(done_o && err_o, "R4 error flag", {done_o, err_o}, 2'b11);
  endtask

  // R8: shutdown
  task automatic t_stop(input bit stuck);
    lock_i = 1'b1;
    log_n = 0;
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    @(negedge clk);
    if (!stuck) begin repeat (3) @(negedge clk); lock_i = 1'b0; end
    wait_idle();
    check(log_n == 2, "R8 write count", log_n, 2);
    check(log_a[0] == 12'h504 && log_d[0] == 32'h000C_0000, "R8 serializer off",
          log_d[0], 32'h000C_0000);
    check(log_a[1] == 12'h510 && log_d[1] == 0, "R8 pll cleared",
          {20'd0, log_a[1]}, 32'h510);
    check(done_o && (err_o == stuck), "R8 result flags", {done_o, err_o}, {1'b1, stuck});
    lock_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!wr_en_o && !busy_o && !done_o && !err_o, "R11 reset state",
          {wr_en_o, busy_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!wr_en_o && !busy_o && !done_o && !err_o, "R11 after release",
          {wr_en_o, busy_o, done_o, err_o}, 0);

    t_stop(1'b0);
    t_start_ok(32'd10_000_000, 0, 1'b0);
    t_stop(1'b0);
    t_start_ok(32'd19_999_999, 2, 1'b0);
    t_stop(1'b1);
    t_start_ok(32'd20_000_000, 1, 1'b0);
    t_stop(1'b0);
    t_start_ok(32'd42_500_000, 3, 1'b1);
    t_stop(1'b0);
    t_start_ok(32'd84_999_999, 0, 1'b0);
    t_stop(1'b0);
    t_start_ok(32'd165_000_000, 2, 1'b0);
    t_stop(1'b0);
    t_start_ok(32'd165_000_001, 2, 1'b0);
    t_stop(1'b0);
    t_start_ok(32'd250_000_000, 1, 1'b0);
    t_stop(1'b0);
    t_start_ok(32'd250_000_001, 1, 1'b0);
    t_stop(1'b0);
    t_start_ok(32'd300_000_000, 1, 1'b0);
    t_stop(1'b0);
    t_start_ok(32'd339_999_999, 4, 1'b1);
    t_stop(1'b0);
    t_reject(32'd340_000_000);
    t_reject(32'hFFFF_FFFF);
    t_timeout();
    t_start_ok(32'd100_000_000, 5, 1'b0);
    t_stop(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule